// File: doc/BRIEF.md
# Backplane Block Transfer Master

This block moves a block of 16-bit words across an asynchronous, fully interlocked backplane bus once another unit has already won bus mastership. Software-side logic loads a start address, a word count, a direction and a slave timeout, then pulses start. For each word the engine puts the address and the transfer control code on the bus. On writes it also puts the data word on the bus. After a deskew interval it raises the master strobe and waits for the slave's reply strobe. On reads it then samples the bus data. It drops the master strobe and holds the address for a second deskew interval before moving to the next word.

Write data comes from a word buffer indexed by the engine. Read data goes back into the same buffer through a one-cycle write strobe. The grant acknowledge is given up while the last word is in flight. Bus busy is held until the whole block is finished. A slave that never answers ends the block with an error, and the address it failed on stays readable. All delays are counted in clock cycles derived from the clock period parameter.

Top module: `blkdma_engine`

## Requirements
- R1: A start pulse taken while idle with a nonzero count raises `busy_o` and `bbsy_o` in the following cycle; a start pulse while busy changes nothing in the running block.
- R2: Word k of a block (k from 0) is carried on bus address start + 2k and uses buffer index k; after a block without error `cur_addr_o` equals the address of the last word.
- R3: While a word is on the bus, `bus_ctl_o` is 2'b00 for a read and 2'b10 for a write, a write drives the buffer word onto `bus_data_o`, and address, control and data do not change while `msyn_o` is high.
- R4: `msyn_o` rises only after address and control have been driven for at least DESKEW_CYC = ceil(DESKEW_NS / CLK_PERIOD_NS) cycles.
- R5: Once `ssyn_i` is seen, `msyn_o` stays high for DESKEW_CYC more cycles; at its fall a read samples `bus_data_i` and writes it to buffer index k with a one-cycle `buf_rd_we_o` pulse.
- R6: From the cycle `msyn_o` falls, `bus_data_o` is zero, while address and control remain on the bus for at least DESKEW_CYC cycles.
- R7: `sack_o` is high from start only while more than one word is left, is low for the whole last word, and is never high without `bbsy_o`.
- R8: Whenever the engine is idle, address, control, data, `msyn_o`, `sack_o` and `bbsy_o` are all zero; a block without error ends with `done_o` high and `err_o` low.
- R9: A start with count zero sets `done_o` in the next cycle and produces no bus activity at all.
- R10: If `ssyn_i` does not arrive within cfg_tmo_us_i microseconds (CLK_PERIOD_NS-based count) of `msyn_o` rising, the strobe is dropped, the block stops with `err_o` high and `done_o` low, `cur_addr_o` holds the failing address, and no buffer write is made for that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse |
| cfg_addr_i | input | ADDR_W | First word address |
| cfg_count_i | input | COUNT_W | Number of words |
| cfg_write_i | input | 1 | 1 = write to slave, 0 = read from slave |
| cfg_tmo_us_i | input | TMO_W | Slave reply limit in microseconds |
| buf_idx_o | output | COUNT_W | Index of the word in flight |
| buf_wr_data_i | input | DATA_W | Buffer word at `buf_idx_o` for writes |
| buf_rd_we_o | output | 1 | Read data strobe into the buffer |
| buf_rd_data_o | output | DATA_W | Read data for the buffer |
| bus_addr_o | output | ADDR_W | Bus address lines |
| bus_ctl_o | output | 2 | Transfer control code |
| bus_data_o | output | DATA_W | Bus data lines driven by the master |
| bus_data_i | input | DATA_W | Bus data lines as received |
| msyn_o | output | 1 | Master strobe |
| ssyn_i | input | 1 | Slave reply strobe |
| sack_o | output | 1 | Grant acknowledge |
| bbsy_o | output | 1 | Bus busy |
| busy_o | output | 1 | Block in progress |
| done_o | output | 1 | Last block finished without error |
| err_o | output | 1 | Last block stopped on a slave timeout |
| cur_addr_o | output | ADDR_W | Current or failing word address |

## Verification
The properties assume that the slave raises `ssyn_i` only while `msyn_o` is high and drops it once the strobe falls. They also assume that `buf_wr_data_i` stays steady for as long as `buf_idx_o` does not move. The bench slave answers after a delay taken from the address bits and lets go of its strobe as soon as the master strobe drops. Its write buffer is a fixed array read by index, so both assumptions hold throughout. Addresses at 128 and above get no answer, and that is how the timeout runs are set up.

// File: rtl/blkdma_pkg.sv
package blkdma_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_LEAD = 3'd1,
    PH_WAIT = 3'd2,
    PH_SAMP = 3'd3,
    PH_TAIL = 3'd4,
    PH_STEP = 3'd5
  } phase_t;

  localparam logic [1:0] CTL_RD = 2'b00;
  localparam logic [1:0] CTL_WR = 2'b10;

  // Round a time up to whole clock cycles, never below one.
  function automatic int ns_to_cycles(input int ns, input int period_ns);
    int c;
    c = (ns + period_ns - 1) / period_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic logic [1:0] ctl_for(input logic wr);
    return wr ? CTL_WR : CTL_RD;
  endfunction

  // Word addresses are byte addresses of 16-bit words.
  function automatic logic [31:0] word_after(input logic [31:0] a);
    return a + 32'd2;
  endfunction

  function automatic logic phase_drives_bus(input phase_t p);
    return (p == PH_LEAD) || (p == PH_WAIT) || (p == PH_SAMP) || (p == PH_TAIL);
  endfunction

  function automatic logic phase_strobes(input phase_t p);
    return (p == PH_WAIT) || (p == PH_SAMP);
  endfunction

endpackage

// File: rtl/blkdma_span.sv
// Counts cycles spent in one phase; restarts on every phase change.
module blkdma_span #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  output logic expired_o
);
  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr_i)          cnt_q <= '0;
    else if (cnt_q != LAST)  cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LAST);
endmodule

// File: rtl/blkdma_watch.sv
// Slave reply timer: a cycle prescaler feeding a microsecond counter.
module blkdma_watch #(
  parameter int CYC_PER_US = 100,
  parameter int LIM_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             expired_o
);
  localparam int PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0]    pre_q;
  logic [LIM_W-1:0] us_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run_i) begin
      pre_q <= '0;
      us_q  <= '0;
    end else if (!expired_o) begin
      if (pre_q == PRE_LAST) begin
        pre_q <= '0;
        us_q  <= us_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign expired_o = (us_q == limit_i);
endmodule

// File: rtl/blkdma_seq.sv
// Per-word phase sequencer of the block transfer master.
module blkdma_seq
  import blkdma_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   go_i,
  input  logic   span_exp_i,
  input  logic   ssyn_i,
  input  logic   tmo_exp_i,
  input  logic   final_i,
  output phase_t phase_o,
  output logic   phase_chg_o,
  output logic   samp_done_o,
  output logic   tmo_hit_o,
  output logic   advance_o,
  output logic   finish_o
);
  phase_t ph_q, ph_n;

  always_comb begin
    ph_n        = ph_q;
    samp_done_o = 1'b0;
    tmo_hit_o   = 1'b0;
    advance_o   = 1'b0;
    finish_o    = 1'b0;
    unique case (ph_q)
      PH_IDLE: if (go_i) ph_n = PH_LEAD;
      PH_LEAD: if (span_exp_i) ph_n = PH_WAIT;
      PH_WAIT: begin
        if (ssyn_i) begin
          ph_n = PH_SAMP;
        end else if (tmo_exp_i) begin
          ph_n      = PH_TAIL;
          tmo_hit_o = 1'b1;
        end
      end
      PH_SAMP: begin
        if (span_exp_i) begin
          ph_n        = PH_TAIL;
          samp_done_o = 1'b1;
        end
      end
      PH_TAIL: if (span_exp_i) ph_n = PH_STEP;
      PH_STEP: begin
        if (final_i) begin
          ph_n     = PH_IDLE;
          finish_o = 1'b1;
        end else begin
          ph_n      = PH_LEAD;
          advance_o = 1'b1;
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ph_q <= PH_IDLE;
    else        ph_q <= ph_n;
  end

  assign phase_o     = ph_q;
  assign phase_chg_o = (ph_n != ph_q);
endmodule

// File: rtl/blkdma_engine.sv
// Block transfer master for an interlocked asynchronous backplane bus.
module blkdma_engine
  import blkdma_pkg::*;
#(
  parameter int ADDR_W        = 18,
  parameter int DATA_W        = 16,
  parameter int COUNT_W       = 8,
  parameter int TMO_W         = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int DESKEW_NS     = 75
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [COUNT_W-1:0] cfg_count_i,
  input  logic               cfg_write_i,
  input  logic [TMO_W-1:0]   cfg_tmo_us_i,
  output logic [COUNT_W-1:0] buf_idx_o,
  input  logic [DATA_W-1:0]  buf_wr_data_i,
  output logic               buf_rd_we_o,
  output logic [DATA_W-1:0]  buf_rd_data_o,
  output logic [ADDR_W-1:0]  bus_addr_o,
  output logic [1:0]         bus_ctl_o,
  output logic [DATA_W-1:0]  bus_data_o,
  input  logic [DATA_W-1:0]  bus_data_i,
  output logic               msyn_o,
  input  logic               ssyn_i,
  output logic               sack_o,
  output logic               bbsy_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o,
  output logic [ADDR_W-1:0]  cur_addr_o
);
  localparam int DESKEW_CYC = ns_to_cycles(DESKEW_NS, CLK_PERIOD_NS);
  localparam int CYC_PER_US = ns_to_cycles(1000, CLK_PERIOD_NS);

  // Named internal events, also seen by the bound checker.
  phase_t ph_w;
  logic   phase_chg_w, span_exp_w, tmo_exp_w;
  logic   samp_done_w, tmo_hit_w, advance_w, finish_w;
  logic   go_w, zero_w, final_w, bus_drive_w, last_word_w, wdata_on_w;

  logic [ADDR_W-1:0]  addr_q;
  logic [COUNT_W-1:0] idx_q, left_q;
  logic               wr_q, bbsy_q, sack_q, done_q, err_q, rd_we_q;
  logic [TMO_W-1:0]   lim_q;
  logic [DATA_W-1:0]  rd_q;

  assign go_w        = start_i && (ph_w == PH_IDLE) && (cfg_count_i != '0);
  assign zero_w      = start_i && (ph_w == PH_IDLE) && (cfg_count_i == '0);
  assign last_word_w = (left_q == COUNT_W'(1));
  assign final_w     = last_word_w || err_q;
  assign bus_drive_w = phase_drives_bus(ph_w);
  assign wdata_on_w  = bus_drive_w && wr_q && (ph_w != PH_TAIL);

  blkdma_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .go_i        (go_w),
    .span_exp_i  (span_exp_w),
    .ssyn_i      (ssyn_i),
    .tmo_exp_i   (tmo_exp_w),
    .final_i     (final_w),
    .phase_o     (ph_w),
    .phase_chg_o (phase_chg_w),
    .samp_done_o (samp_done_w),
    .tmo_hit_o   (tmo_hit_w),
    .advance_o   (advance_w),
    .finish_o    (finish_w)
  );

  blkdma_span #(.LIMIT(DESKEW_CYC)) u_span (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (phase_chg_w || (ph_w == PH_IDLE)),
    .expired_o (span_exp_w)
  );

  blkdma_watch #(.CYC_PER_US(CYC_PER_US), .LIM_W(TMO_W)) u_watch (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_i     (ph_w == PH_WAIT),
    .limit_i   (lim_q),
    .expired_o (tmo_exp_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q  <= '0;
      idx_q   <= '0;
      left_q  <= '0;
      wr_q    <= 1'b0;
      lim_q   <= '0;
      bbsy_q  <= 1'b0;
      sack_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      rd_q    <= '0;
      rd_we_q <= 1'b0;
    end else begin
      rd_we_q <= 1'b0;
      if (go_w) begin
        addr_q <= cfg_addr_i;
        idx_q  <= '0;
        left_q <= cfg_count_i;
        wr_q   <= cfg_write_i;
        lim_q  <= cfg_tmo_us_i;
        bbsy_q <= 1'b1;
        sack_q <= (cfg_count_i != COUNT_W'(1));
        done_q <= 1'b0;
        err_q  <= 1'b0;
      end else if (zero_w) begin
        addr_q <= cfg_addr_i;
        done_q <= 1'b1;
        err_q  <= 1'b0;
      end
      if (samp_done_w && !wr_q) begin
        rd_q    <= bus_data_i;
        rd_we_q <= 1'b1;
      end
      if (tmo_hit_w) err_q <= 1'b1;
      if (advance_w) begin
        addr_q <= ADDR_W'(word_after(32'(addr_q)));
        idx_q  <= idx_q + 1'b1;
        left_q <= left_q - 1'b1;
        sack_q <= (left_q != COUNT_W'(2));
      end
      if (finish_w) begin
        bbsy_q <= 1'b0;
        sack_q <= 1'b0;
        done_q <= !err_q;
      end
    end
  end

  assign bus_addr_o    = bus_drive_w ? addr_q : '0;
  assign bus_ctl_o     = bus_drive_w ? ctl_for(wr_q) : 2'b00;
  assign bus_data_o    = wdata_on_w ? buf_wr_data_i : '0;
  assign msyn_o        = phase_strobes(ph_w);
  assign sack_o        = sack_q;
  assign bbsy_o        = bbsy_q;
  assign buf_idx_o     = idx_q;
  assign buf_rd_we_o   = rd_we_q;
  assign buf_rd_data_o = rd_q;
  assign busy_o        = (ph_w != PH_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign cur_addr_o    = addr_q;
endmodule

// File: rtl/blkdma_engine_chk.sv
module blkdma_engine_chk #(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int COUNT_W    = 8,
  parameter int DESKEW_CYC = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start_i,
  input logic [COUNT_W-1:0] cfg_count_i,
  input logic               busy_o,
  input logic               done_o,
  input logic               err_o,
  input logic               msyn_o,
  input logic               sack_o,
  input logic               bbsy_o,
  input logic [ADDR_W-1:0]  bus_addr_o,
  input logic [1:0]         bus_ctl_o,
  input logic [DATA_W-1:0]  bus_data_o,
  input logic [ADDR_W-1:0]  cur_addr_o,
  input logic               bus_drive_w,
  input logic               last_word_w,
  input logic               advance_w
);
  logic [15:0] lead_cnt, tail_cnt;

  // Cycles address has been driven with the strobe still low.
  always_ff @(posedge clk) begin
    if (!rst_n || !bus_drive_w)   lead_cnt <= '0;
    else if (!msyn_o && lead_cnt != 16'hFFFF) lead_cnt <= lead_cnt + 1'b1;
  end

  // Cycles address has stayed on the bus since the strobe fell.
  always_ff @(posedge clk) begin
    if (!rst_n || msyn_o) tail_cnt <= '0;
    else if (bus_drive_w && tail_cnt != 16'hFFFF) tail_cnt <= tail_cnt + 1'b1;
  end

  a_r1_start_claims: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && cfg_count_i != '0) |=> (busy_o && bbsy_o));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    advance_w |=> (cur_addr_o == $past(cur_addr_o) + ADDR_W'(2)));

  a_r3_frozen_under_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (msyn_o && $past(msyn_o)) |-> ($stable(bus_addr_o) && $stable(bus_ctl_o) && $stable(bus_data_o)));

  a_r4_lead_time: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msyn_o) |-> (lead_cnt >= 16'(DESKEW_CYC)));

  a_r6_tail_time: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_drive_w) |-> (tail_cnt >= 16'(DESKEW_CYC)));

  a_r6_data_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(msyn_o) |-> (bus_data_o == '0));

  a_r7_sack_in_bbsy: assert property (@(posedge clk) disable iff (!rst_n)
    sack_o |-> bbsy_o);

  a_r7_sack_last_off: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && last_word_w) |-> !sack_o);

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!bbsy_o && !sack_o && !msyn_o && bus_addr_o == '0 && bus_ctl_o == 2'b00 && bus_data_o == '0));

  a_r9_zero_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && cfg_count_i == '0) |=> (!busy_o && !bbsy_o && done_o));

  a_r10_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

bind blkdma_engine blkdma_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .COUNT_W(COUNT_W), .DESKEW_CYC(DESKEW_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_count_i(cfg_count_i),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .msyn_o(msyn_o),
  .sack_o(sack_o), .bbsy_o(bbsy_o), .bus_addr_o(bus_addr_o), .bus_ctl_o(bus_ctl_o),
  .bus_data_o(bus_data_o), .cur_addr_o(cur_addr_o), .bus_drive_w(bus_drive_w),
  .last_word_w(last_word_w), .advance_w(advance_w)
);

// File: tb/blkdma_engine_test.sv
module blkdma_engine_test;
  localparam int AW  = 18;
  localparam int DW  = 16;
  localparam int CW  = 8;
  localparam int TW  = 8;
  localparam int D   = (75 + 10 - 1) / 10;
  localparam int CPU = 1000 / 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_count = '0;
  logic          cfg_write = 1'b0;
  logic [TW-1:0] cfg_tmo = 8'd2;
  logic [CW-1:0] buf_idx;
  logic [DW-1:0] buf_wdata;
  logic          buf_we;
  logic [DW-1:0] buf_rdata;
  logic [AW-1:0] bus_addr;
  logic [1:0]    bus_ctl;
  logic [DW-1:0] bus_dout;
  logic [DW-1:0] sdata = '0;
  logic          msyn;
  logic          ssyn = 1'b0;
  logic          sack, bbsy, busy, done, err;
  logic [AW-1:0] cur_addr;

  logic [DW-1:0] wbuf   [0:31];
  logic [DW-1:0] mem    [0:63];
  logic [DW-1:0] shadow [0:63];

  assign buf_wdata = wbuf[buf_idx[4:0]];

  blkdma_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .cfg_addr_i(cfg_addr),
    .cfg_count_i(cfg_count), .cfg_write_i(cfg_write), .cfg_tmo_us_i(cfg_tmo),
    .buf_idx_o(buf_idx), .buf_wr_data_i(buf_wdata), .buf_rd_we_o(buf_we),
    .buf_rd_data_o(buf_rdata), .bus_addr_o(bus_addr), .bus_ctl_o(bus_ctl),
    .bus_data_o(bus_dout), .bus_data_i(sdata), .msyn_o(msyn), .ssyn_i(ssyn),
    .sack_o(sack), .bbsy_o(bbsy), .busy_o(busy), .done_o(done), .err_o(err),
    .cur_addr_o(cur_addr)
  );

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
      $finish;
    end
  endtask

  // Slave: answers below address 128 after an address-dependent delay.
  int sdly = 0;
  always @(negedge clk) begin
    if (!msyn) begin
      ssyn <= 1'b0;
      sdata <= '0;
      sdly = 0;
    end else if (!ssyn && bus_addr < 128) begin
      if (sdly >= int'(bus_addr[3:1])) begin
        ssyn <= 1'b1;
        if (bus_ctl == 2'b10) mem[bus_addr[6:1]] <= bus_dout;
        else                  sdata <= mem[bus_addr[6:1]];
      end else begin
        sdly++;
      end
    end
  end

  typedef struct { logic [AW-1:0] addr; logic [1:0] ctl; logic [DW-1:0] data; bit last; } bus_item_t;
  typedef struct { logic [CW-1:0] idx; logic [DW-1:0] data; } rd_item_t;
  bus_item_t exp_bus[$];
  rd_item_t  exp_rd[$];

  // Monitor: scoreboard pops and handshake timing.
  logic          msyn_d = 1'b0;
  int            lead_n = 0, both_n = 0, wait_n = 0, last_wait = 0, tail_n = 0;
  logic [AW-1:0] lead_addr = '0, tail_addr = '0;
  bit            tail_on = 0;
  int            rises = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (msyn && !msyn_d) begin
        rises++;
        if (exp_bus.size() == 0) chk(0, "R3", "unexpected bus cycle at", bus_addr, 0);
        else begin
          bus_item_t it;
          it = exp_bus.pop_front();
          chk(bus_addr == it.addr, "R2", "word address", bus_addr, it.addr);
          chk(bus_ctl == it.ctl, "R3", "control code", bus_ctl, it.ctl);
          if (it.ctl == 2'b10) chk(bus_dout == it.data, "R3", "write data", bus_dout, it.data);
          chk(sack == !it.last, "R7", "sack during word", sack, !it.last);
          chk(bbsy, "R7", "bbsy during word", bbsy, 1);
          chk(lead_n >= D, "R4", "address lead cycles", lead_n, D);
        end
        both_n = 0;
        wait_n = 0;
      end
      if (msyn && ssyn)  both_n++;
      if (msyn && !ssyn) wait_n++;
      if (!msyn && msyn_d) begin
        last_wait = wait_n;
        if (both_n > 0) chk(both_n >= D, "R5", "strobe after reply", both_n, D);
        chk(bus_dout == '0, "R6", "data at strobe fall", bus_dout, 0);
        tail_on = 1; tail_addr = bus_addr; tail_n = 1;
      end else if (tail_on) begin
        if (!msyn && bus_addr == tail_addr) tail_n++;
        else begin
          chk(tail_n >= D, "R6", "address hold after strobe", tail_n, D);
          tail_on = 0;
        end
      end
      if (!msyn) begin
        if (bus_addr == lead_addr) lead_n++;
        else begin lead_addr = bus_addr; lead_n = 1; end
      end
      if (buf_we) begin
        if (exp_rd.size() == 0) chk(0, "R10", "unexpected buffer write", buf_idx, 0);
        else begin
          rd_item_t r;
          r = exp_rd.pop_front();
          chk(buf_idx == r.idx, "R5", "read buffer index", buf_idx, r.idx);
          chk(buf_rdata == r.data, "R5", "read data", buf_rdata, r.data);
        end
      end
    end
    msyn_d = msyn;
  end

  // Driver: pushes expected items, then runs one block.
  task automatic run_block(input logic [AW-1:0] a, input int n, input bit wr,
                           input int tmo, input bit poke);
    int fail_k = -1;
    for (int k = 0; k < n; k++) begin
      bus_item_t it;
      logic [AW-1:0] ak;
      ak = a + AW'(2 * k);
      it.addr = ak; it.ctl = wr ? 2'b10 : 2'b00; it.data = wbuf[k]; it.last = (k == n - 1);
      exp_bus.push_back(it);
      if (ak >= 128) begin fail_k = k; break; end
      if (wr) shadow[ak[6:1]] = wbuf[k];
      else begin
        rd_item_t r;
        r.idx = CW'(k); r.data = shadow[ak[6:1]];
        exp_rd.push_back(r);
      end
    end
    @(negedge clk);
    cfg_addr = a; cfg_count = CW'(n); cfg_write = wr; cfg_tmo = TW'(tmo); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && bbsy, "R1", "busy and bbsy after start", {busy, bbsy}, 2'b11);
    if (poke) begin
      repeat (15) @(negedge clk);
      cfg_addr = 18'h40; cfg_count = 8'd3; cfg_write = !wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int c = 0; c < 20000 && busy; c++) @(negedge clk);
    chk(!busy, "R8", "block finishes", busy, 0);
    chk(exp_bus.size() == 0, "R2", "words left unseen", exp_bus.size(), 0);
    chk(exp_rd.size() == 0, "R5", "reads left unseen", exp_rd.size(), 0);
    chk(!bbsy && !sack && !msyn, "R8", "bus released", {bbsy, sack, msyn}, 0);
    chk(bus_addr == '0 && bus_ctl == 2'b00, "R8", "address cleared", bus_addr, 0);
    if (fail_k < 0) begin
      chk(done && !err, "R8", "done status", {done, err}, 2'b10);
      chk(cur_addr == a + AW'(2 * (n - 1)), "R2", "final address", cur_addr, a + AW'(2 * (n - 1)));
    end else begin
      chk(err && !done, "R10", "error status", {done, err}, 2'b01);
      chk(cur_addr == a + AW'(2 * fail_k), "R10", "failing address", cur_addr, a + AW'(2 * fail_k));
      chk(last_wait >= tmo * CPU && last_wait <= tmo * CPU + 2, "R10",
          "strobe wait before timeout", last_wait, tmo * CPU);
    end
    exp_bus.delete();
    exp_rd.delete();
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mem[i] = 16'h1000 + 16'(i * 37);
      shadow[i] = mem[i];
    end
    for (int i = 0; i < 32; i++) wbuf[i] = 16'hC000 ^ 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !err && !bbsy && !msyn && !sack, "R8", "reset state",
        {busy, done, err, bbsy, msyn, sack}, 0);

    run_block(18'h10, 4, 1'b0, 2, 1'b0);          // R2 R5 multi-word read
    run_block(18'h20, 5, 1'b1, 2, 1'b0);          // R3 multi-word write
    for (int i = 16; i < 21; i++)
      chk(mem[i] == shadow[i], "R3", "slave word after write", mem[i], shadow[i]);
    run_block(18'h36, 1, 1'b0, 2, 1'b0);          // R7 single word: no sack
    for (int i = 0; i < 32; i++) wbuf[i] = 16'h5A00 + 16'(i * 3);
    run_block(18'h0A, 3, 1'b1, 2, 1'b1);          // R1 start while busy ignored
    for (int i = 5; i < 8; i++)
      chk(mem[i] == shadow[i], "R1", "slave word after poked block", mem[i], shadow[i]);

    // R9: zero count
    begin
      int r0;
      r0 = rises;
      @(negedge clk);
      cfg_addr = 18'h44; cfg_count = 8'd0; cfg_write = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(done && !busy && !bbsy && !err, "R9", "zero count status", {done, busy, bbsy, err}, 4'b1000);
      repeat (20) @(negedge clk);
      chk(rises == r0 && !msyn, "R9", "no strobe on zero count", rises - r0, 0);
    end

    run_block(18'h7C, 4, 1'b0, 2, 1'b0);          // R10 read stops at 0x80
    run_block(18'h80, 3, 1'b1, 1, 1'b0);          // R10 write fails first word
    run_block(18'h02, 2, 1'b0, 2, 1'b0);          // R10 recovery after error
    wrap_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R8", "watchdog expired", 0, 1);
    wrap_up();
  end
endmodule